// File: doc/BRIEF.md
# Broadcast-Sample FIR Convolution Array

This block computes a finite impulse response convolution on a linear array of K multiply-accumulate cells. Each accepted input sample reaches every cell in the same clock over one shared line. The K coefficients travel around a ring, one cell further for each accepted sample. Each output term stays in its own cell and accumulates there in a register wider than the coefficients, so no bits are lost. When a cell has summed K products, its total moves into a shared output register and that cell starts again from zero.

The block has three streams. The coefficient stream loads a full set of K values, and loading resets the sample history. The sample stream carries the input sequence. The result stream returns each finished sum. The sample and result streams use valid/ready handshakes. A transfer takes place on a rising clock edge where both valid and ready are high. A result stays on the port without change until the consumer accepts it. While a result waits, the sample port deasserts ready, so no sum is ever dropped. Coefficient beats are always accepted.

Top module: `bcast_conv`

## Requirements
- R1: After reset, `y_valid` is 0 and `in_ready` is 0 until a full set of K coefficients has arrived. `w_ready` is always 1.
- R2: A coefficient set is K beats on `w_data`: the first beat is w1 and the K-th beat is wK. Any beat after a complete set starts a new set and discards all partial sums and all sample history.
- R3: Samples and coefficients are signed two's complement, DATA_W bits wide. Result i equals w1·x_i + w2·x_(i+1) + … + wK·x_(i+K-1), computed exactly in ACC_W = 2·DATA_W + ceil(log2 K) bits, including at the most negative operand values.
- R4: For N samples accepted since the last complete coefficient set, exactly N+1-K results are produced. No result appears before K samples have been accepted.
- R5: The result that ends with sample x_(i+K-1) is on `y_data` with `y_valid` high in the cycle right after the clock edge that accepts that sample.
- R6: While `y_valid` is 1 and `y_ready` is 0, `y_data` holds its value, `y_valid` stays 1, and `in_ready` is 0.
- R7: A coefficient beat has priority over samples: `in_ready` is 0 in any cycle where `w_valid` is 1.
- R8: After loading, the coefficients keep circulating, so a stream much longer than K gives correct results on every period of the ring.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| w_valid | input | 1 | Coefficient beat present |
| w_ready | output | 1 | Coefficient port ready (always 1) |
| w_data | input | DATA_W | Signed coefficient, sent w1 first |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Array can take a sample |
| in_data | input | DATA_W | Signed input sample |
| y_valid | output | 1 | Result present |
| y_ready | input | 1 | Consumer takes the result |
| y_data | output | ACC_W | Signed convolution result |

## Verification
The only register between the inputs and the result port is the output register. So result i is due in the cycle right after the edge that accepts sample x_(i+K-1), and it stays there until `y_ready` takes it. The bench drives inputs on falling edges. It samples two nanoseconds later, before the next rising edge, and it records a result only when valid and ready are both high at that moment. The timing scenario counts accepted samples and looks at the port exactly one edge after the K-th sample. The other scenarios collect every handshaken result in order and compare each one with a reference sum computed in the bench.

// File: rtl/bcast_conv_pkg.sv
package bcast_conv_pkg;
  // accumulator width that holds K full-scale products without wrap
  function automatic int acc_width(input int data_w, input int k);
    return 2 * data_w + $clog2(k);
  endfunction
endpackage

// File: rtl/bcast_conv_cell.sv
module bcast_conv_cell #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 18
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     step,
  input  logic                     fin,
  input  logic                     ld_en,
  input  logic signed [DATA_W-1:0] ld_w,
  input  logic signed [DATA_W-1:0] w_prev,
  input  logic signed [DATA_W-1:0] x_bc,
  output logic signed [DATA_W-1:0] w_cur,
  output logic signed [ACC_W-1:0]  sum
);
  localparam int PROD_W = 2 * DATA_W;

  logic signed [DATA_W-1:0] w_q;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;

  assign prod     = w_q * x_bc;
  assign prod_ext = ACC_W'(prod);
  assign sum      = acc_q + prod_ext;
  assign w_cur    = w_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      w_q   <= '0;
      acc_q <= '0;
    end else begin
      if (ld_en)      w_q <= ld_w;
      else if (step)  w_q <= w_prev;
      if (clr)        acc_q <= '0;
      else if (step)  acc_q <= fin ? '0 : sum;
    end
  end
endmodule

// File: rtl/bcast_conv_ctrl.sv
module bcast_conv_ctrl #(
  parameter int K = 4,
  localparam int PW = (K > 1) ? $clog2(K) : 1,
  localparam int CW = $clog2(K + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          w_valid,
  input  logic          in_valid,
  input  logic          out_blocked,
  output logic          w_ready,
  output logic          in_ready,
  output logic          w_fire,
  output logic [PW-1:0] ld_sel,
  output logic          step,
  output logic          clr,
  output logic [PW-1:0] fin_idx,
  output logic          emit
);
  logic [CW-1:0] wcnt_q, slot;
  logic [PW-1:0] ph_q, seen_q;
  logic          loaded;

  assign loaded   = (wcnt_q == CW'(K));
  assign slot     = loaded ? '0 : wcnt_q;
  assign ld_sel   = (slot == '0) ? '0 : PW'(K - int'(slot));
  assign w_ready  = 1'b1;
  assign w_fire   = w_valid;
  assign clr      = w_fire;
  assign in_ready = loaded && !w_valid && !out_blocked;
  assign step     = in_valid && in_ready;
  assign fin_idx  = (ph_q == PW'(K - 1)) ? '0 : ph_q + 1'b1;
  assign emit     = step && (seen_q == PW'(K - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      ph_q   <= '0;
      seen_q <= '0;
    end else if (w_fire) begin
      wcnt_q <= slot + 1'b1;
      ph_q   <= '0;
      seen_q <= '0;
    end else if (step) begin
      ph_q <= fin_idx;
      if (seen_q != PW'(K - 1)) seen_q <= seen_q + 1'b1;
    end
  end
endmodule

// File: rtl/bcast_conv.sv
module bcast_conv #(
  parameter int DATA_W = 8,
  parameter int K      = 4,
  localparam int ACC_W = bcast_conv_pkg::acc_width(DATA_W, K),
  localparam int PW    = (K > 1) ? $clog2(K) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              w_valid,
  output logic              w_ready,
  input  logic [DATA_W-1:0] w_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              y_valid,
  input  logic              y_ready,
  output logic [ACC_W-1:0]  y_data
);
  logic signed [DATA_W-1:0] w_cur [K];
  logic signed [ACC_W-1:0]  sums  [K];
  logic [PW-1:0] ld_sel, fin_idx;
  logic          w_fire, step, clr, emit, out_blocked;
  logic          y_valid_q;
  logic [ACC_W-1:0] y_q;

  assign out_blocked = y_valid_q && !y_ready;

  bcast_conv_ctrl #(.K(K)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .w_valid(w_valid), .in_valid(in_valid),
    .out_blocked(out_blocked), .w_ready(w_ready), .in_ready(in_ready),
    .w_fire(w_fire), .ld_sel(ld_sel), .step(step), .clr(clr),
    .fin_idx(fin_idx), .emit(emit)
  );

  for (genvar g = 0; g < K; g++) begin : g_cell
    localparam int PREV = (g == 0) ? K - 1 : g - 1;
    bcast_conv_cell #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_cell (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
      .fin(fin_idx == PW'(g)),
      .ld_en(w_fire && (ld_sel == PW'(g))),
      .ld_w($signed(w_data)), .w_prev(w_cur[PREV]),
      .x_bc($signed(in_data)), .w_cur(w_cur[g]), .sum(sums[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_valid_q <= 1'b0;
      y_q       <= '0;
    end else if (emit) begin
      y_valid_q <= 1'b1;
      y_q       <= sums[fin_idx];
    end else if (y_ready) begin
      y_valid_q <= 1'b0;
    end
  end

  assign y_valid = y_valid_q;
  assign y_data  = y_q;
endmodule

// File: rtl/bcast_conv_chk.sv
module bcast_conv_chk #(
  parameter int K     = 4,
  parameter int ACC_W = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             w_valid,
  input logic             in_valid,
  input logic             in_ready,
  input logic             y_valid,
  input logic             y_ready,
  input logic [ACC_W-1:0] y_data,
  input logic             emit
);
  localparam int CW = $clog2(K + 1);
  logic [CW-1:0] acc_n;   // samples accepted since last beat, saturating
  logic [CW-1:0] wb_n;    // coefficient beats in the current set

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_n <= '0;
      wb_n  <= '0;
    end else if (w_valid) begin
      acc_n <= '0;
      wb_n  <= (wb_n == CW'(K)) ? CW'(1) : wb_n + 1'b1;
    end else if (in_valid && in_ready && acc_n != CW'(K)) begin
      acc_n <= acc_n + 1'b1;
    end
  end

  p_ready_needs_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (wb_n == CW'(K)));
  p_no_early_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    emit |-> (acc_n >= CW'(K - 1)));
  p_result_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(y_valid) |-> $past(in_valid && in_ready));
  p_hold_result_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid && !y_ready) |=> (y_valid && $stable(y_data)));
  p_stall_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (y_valid && !y_ready) |-> !in_ready);
  p_beat_priority_r7: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid |-> !in_ready);
endmodule

bind bcast_conv bcast_conv_chk #(.K(K), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .w_valid(w_valid), .in_valid(in_valid),
  .in_ready(in_ready), .y_valid(y_valid), .y_ready(y_ready),
  .y_data(y_data), .emit(emit)
);

// File: tb/bcast_conv_bench.sv
module bcast_conv_bench;
  localparam int DATA_W = 8;
  localparam int K      = 4;
  localparam int ACC_W  = 2 * DATA_W + $clog2(K);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic w_valid = 1'b0, in_valid = 1'b0, y_ready = 1'b1;
  logic [DATA_W-1:0] w_data = '0, in_data = '0;
  logic w_ready, in_ready, y_valid;
  logic [ACC_W-1:0] y_data;

  bcast_conv #(.DATA_W(DATA_W), .K(K)) u_bcast_conv (
    .clk(clk), .rst_n(rst_n), .w_valid(w_valid), .w_ready(w_ready),
    .w_data(w_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .y_valid(y_valid), .y_ready(y_ready), .y_data(y_data)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_chk = 0, n_bad = 0;
  int got [0:63];
  int gcnt = 0;
  int bp_on = 0, bp_viol = 0, cyc = 0;
  int wv [0:K-1];
  int xs [0:63];
  int ldr_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // result monitor: sets y_ready at the falling edge, samples 2 ns later
  always @(negedge clk) begin
    y_ready = (bp_on != 0) ? ((cyc % 3) == 2) : 1'b1;
    #2;
    if (y_valid && y_ready && gcnt < 64) begin
      got[gcnt] = $signed(y_data);
      gcnt++;
    end
    if (y_valid && !y_ready && in_ready) bp_viol++;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic load_w();
    for (int j = 0; j < K; j++) begin
      @(negedge clk);
      w_valid = 1'b1;
      w_data  = DATA_W'(wv[j]);
      #2;
      if (in_ready) ldr_bad = 1;
      @(posedge clk);
      #1;
    end
    w_valid = 1'b0;
  endtask

  task automatic send_x(input int v);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = DATA_W'(v);
    #2;
    while (!in_ready) begin
      @(negedge clk);
      #2;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (8) @(posedge clk);
  endtask

  function automatic int ref_y(input int base, input int i);
    int s = 0;
    for (int j = 0; j < K; j++) s += wv[j] * xs[base + i + j];
    return s;
  endfunction

  // n samples in xs[base..]; results expected in got[g0..]
  task automatic check_results(input string req, input int base, input int n, input int g0);
    chk({req, " count"}, gcnt - g0, n + 1 - K);
    for (int i = 0; i < n + 1 - K; i++) chk({req, " value"}, got[g0 + i], ref_y(base, i));
  endtask

  task automatic t_reset();
    chk("R1 y_valid after reset", y_valid, 0);
    chk("R1 in_ready without weights", in_ready, 0);
    chk("R1 w_ready", w_ready, 1);
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'd5;
    repeat (3) @(posedge clk);
    #2;
    chk("R1 in_ready stays low unloaded", in_ready, 0);
    in_valid = 1'b0;
    chk("R1 no result unloaded", gcnt, 0);
  endtask

  task automatic t_basic();  // R3 R4 R8: long stream, several ring periods
    wv[0] = 1; wv[1] = 2; wv[2] = 3; wv[3] = 4;
    load_w();
    gcnt = 0;
    for (int i = 0; i < 14; i++) begin xs[i] = i + 1; send_x(xs[i]); end
    drain();
    check_results("R8 ring stream", 0, 14, 0);
  endtask

  task automatic t_extreme();  // R3 full-scale operands
    for (int j = 0; j < K; j++) wv[j] = -128;
    load_w();
    gcnt = 0;
    for (int i = 0; i < 6; i++) begin xs[i] = -128; send_x(xs[i]); end
    drain();
    check_results("R3 neg*neg", 0, 6, 0);
    for (int j = 0; j < K; j++) wv[j] = 127;
    load_w();
    gcnt = 0;
    for (int i = 0; i < 5; i++) begin xs[i] = (i % 2 == 0) ? -128 : 127; send_x(xs[i]); end
    drain();
    check_results("R3 mixed extremes", 0, 5, 0);
  endtask

  task automatic t_timing();  // R5 and R4 warm-up
    wv[0] = 2; wv[1] = -3; wv[2] = 1; wv[3] = 7;
    load_w();
    gcnt = 0;
    for (int i = 0; i < K - 1; i++) begin xs[i] = 10 * i - 9; send_x(xs[i]); end
    @(negedge clk); #2;
    chk("R4 no result before K samples", y_valid, 0);
    xs[K-1] = 33;
    send_x(xs[K-1]);
    chk("R5 valid one edge after K-th sample", y_valid, 1);
    chk("R5 value one edge after K-th sample", $signed(y_data), ref_y(0, 0));
    drain();
  endtask

  task automatic t_backpressure();  // R6
    wv[0] = 3; wv[1] = -1; wv[2] = 2; wv[3] = 5;
    load_w();
    gcnt = 0; bp_viol = 0; bp_on = 1;
    for (int i = 0; i < 12; i++) begin xs[i] = (i * 37) % 200 - 100; send_x(xs[i]); end
    drain();
    bp_on = 0;
    drain();
    check_results("R6 stalled stream", 0, 12, 0);
    chk("R6 in_ready while result waits", bp_viol, 0);
  endtask

  task automatic t_reload();  // R2 R4 R7
    int g0;
    wv[0] = 1; wv[1] = 1; wv[2] = 1; wv[3] = 1;
    load_w();
    gcnt = 0;
    for (int i = 0; i < 6; i++) begin xs[i] = i + 20; send_x(xs[i]); end
    drain();
    chk("R2 first set count", gcnt, 3);
    // new set while a sample is also offered: beats win
    wv[0] = 4; wv[1] = -2; wv[2] = 0; wv[3] = 9;
    ldr_bad = 0;
    @(negedge clk);
    in_valid = 1'b1; in_data = 8'd77;
    load_w();
    in_valid = 1'b0;
    chk("R7 in_ready low during beats", ldr_bad, 0);
    g0 = gcnt;
    for (int i = 0; i < K - 1; i++) begin xs[i] = 3 * i - 5; send_x(xs[i]); end
    drain();
    chk("R4 no result after reload warm-up", gcnt - g0, 0);
    for (int i = K - 1; i < 7; i++) begin xs[i] = 11 - 2 * i; send_x(xs[i]); end
    drain();
    check_results("R2 history cleared", 0, 7, g0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #2;
    t_reset();
    t_basic();
    t_extreme();
    t_timing();
    t_backpressure();
    t_reload();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule